// File: doc/BRIEF.md
# Reconfiguration Control Bus Front End

This block sits between a word-addressed memory-mapped bus and a reconfiguration sequencer. The bus side has a one-bit word address, 32-bit read and write data, and a waitrequest output. The sequencer side has three signals that the sequencer uses: a start pulse, a level that selects a two-pass (double-cycle) event, and a 3-bit status code that the block reads back. The block also feeds a word stream with valid/ready flow control that carries the bitstream.

Software starts an event with a write to the control word. The value 0x1 starts a single-pass event and 0x3 starts a two-pass event. The start bit clears itself, so software never writes it back to zero. Software then writes every bitstream word to the data word. A data write is held on the bus with waitrequest until the stream sink accepts the word, so no word is lost. Software polls the control word to follow the status code.

The reset input is active low and asynchronous. Its release is expected to be synchronous to the clock.

Top module: `recfg_mm_front`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the start output, the double-cycle output, waitrequest and the stream valid are all low.
- R2: A bus write to word 0 puts the write data on the stream data output and raises stream valid in the same cycle. Every accepted word reaches the stream once, in the order written.
- R3: During a write to word 0, waitrequest equals the inverse of stream ready. The write completes on the first clock edge at which ready is high.
- R4: A read of word 0 returns all zeros, whatever was written there before.
- R5: A write to word 1 with bit 0 set makes the start output high for exactly the one cycle after the write edge. Start then returns low without any further write.
- R6: Bit 1 of a write to word 1 sets the double-cycle output from the following cycle. The output holds that value until the next write to word 1.
- R7: A read of word 1 returns the start output in bit 0, the double-cycle output in bit 1 and the sequencer status code in bits 4:2. The data is valid in the same cycle as the read.
- R8: Bits 31:5 of word 1 read back as zero. Writing ones to them changes no output.
- R9: Reads of either word and writes to word 1 never raise waitrequest and never raise stream valid, even while stream ready is low.
- R10: Writing 0x3 to word 1 makes start and double-cycle high together in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mm_addr_i | input | 1 | Word address: 0 data, 1 control/status |
| mm_read_i | input | 1 | Read request |
| mm_write_i | input | 1 | Write request |
| mm_wdata_i | input | 32 | Write data |
| mm_rdata_o | output | 32 | Read data, valid in the read cycle |
| mm_waitreq_o | output | 1 | Stall for the current transfer |
| seq_status_i | input | 3 | Status code from the sequencer |
| seq_start_o | output | 1 | One-cycle start pulse |
| seq_double_o | output | 1 | Two-pass event select |
| wd_data_o | output | 32 | Bitstream word to the sink |
| wd_valid_o | output | 1 | Bitstream word valid |
| wd_ready_i | input | 1 | Sink ready |

## Verification
Data writes are tried with the sink ready at once, and then with ready held low for one or three cycles. This separates a correct stall from a word that is dropped or passed twice. Control writes of 0x1, 0x3, 0x0 and a value with every reserved bit set separate the self-clearing start bit from the held double-cycle bit and from the reserved bits. Status reads walk all eight codes so that a swapped or shifted field shows up. Register reads and control writes are also made while ready is low, to expose any stall that leaks onto non-data accesses.

// File: rtl/recfg_mm_pkg.sv
package recfg_mm_pkg;
  localparam int unsigned BUS_W     = 32;
  localparam int unsigned STAT_W    = 3;
  localparam int unsigned START_BIT = 0;
  localparam int unsigned DBL_BIT   = 1;
  localparam int unsigned STAT_LSB  = 2;
  localparam int unsigned FIELD_TOP = STAT_LSB + STAT_W;

  typedef enum logic {
    WORD_DATA = 1'b0,
    WORD_CTRL = 1'b1
  } word_sel_e;

  typedef struct packed {
    logic data_wr;
    logic ctrl_wr;
    logic ctrl_rd;
  } access_t;
endpackage

// File: rtl/recfg_addr_decode.sv
module recfg_addr_decode
  import recfg_mm_pkg::*;
(
  input  logic    addr_i,
  input  logic    read_i,
  input  logic    write_i,
  output access_t acc_o
);
  word_sel_e sel;

  always_comb begin
    sel           = word_sel_e'(addr_i);
    acc_o.data_wr = write_i && (sel == WORD_DATA);
    acc_o.ctrl_wr = write_i && (sel == WORD_CTRL);
    acc_o.ctrl_rd = read_i  && (sel == WORD_CTRL);
  end
endmodule

// File: rtl/recfg_ctrl_reg.sv
module recfg_ctrl_reg
  import recfg_mm_pkg::*;
#(
  parameter int unsigned DATA_W = BUS_W,
  parameter int unsigned ST_W   = STAT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_start_i,
  input  logic              wr_dbl_i,
  input  logic [ST_W-1:0]   status_i,
  output logic              start_o,
  output logic              dbl_o,
  output logic [DATA_W-1:0] word_o
);
  localparam int unsigned USED_W = STAT_LSB + ST_W;
  localparam int unsigned RSVD_W = DATA_W - USED_W;

  logic start_q, start_d;
  logic dbl_q, dbl_d;

  // Next state: the start bit defaults to clear, so it self-clears.
  always_comb begin
    start_d = 1'b0;
    dbl_d   = dbl_q;
    if (wr_en_i) begin
      start_d = wr_start_i;
      dbl_d   = wr_dbl_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
    end else begin
      start_q <= start_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dbl_q <= 1'b0;
    end else if (wr_en_i) begin
      dbl_q <= dbl_d;
    end
  end

  generate
    if (RSVD_W > 0) begin : g_pad
      assign word_o = {{RSVD_W{1'b0}}, status_i, dbl_q, start_q};
    end else begin : g_nopad
      assign word_o = {status_i, dbl_q, start_q};
    end
  endgenerate

  assign start_o = start_q;
  assign dbl_o   = dbl_q;
endmodule

// File: rtl/recfg_word_port.sv
module recfg_word_port #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              push_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ready_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              stall_o
);
  // Pass-through: the bus master holds the word while the sink stalls.
  always_comb begin
    valid_o = push_i;
    data_o  = wdata_i;
    stall_o = push_i && !ready_i;
  end
endmodule

// File: rtl/recfg_mm_front.sv
module recfg_mm_front
  import recfg_mm_pkg::*;
#(
  parameter int unsigned DATA_W = BUS_W,
  parameter int unsigned ST_W   = STAT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mm_addr_i,
  input  logic              mm_read_i,
  input  logic              mm_write_i,
  input  logic [DATA_W-1:0] mm_wdata_i,
  output logic [DATA_W-1:0] mm_rdata_o,
  output logic              mm_waitreq_o,
  input  logic [ST_W-1:0]   seq_status_i,
  output logic              seq_start_o,
  output logic              seq_double_o,
  output logic [DATA_W-1:0] wd_data_o,
  output logic              wd_valid_o,
  input  logic              wd_ready_i
);
  access_t           acc;
  logic [DATA_W-1:0] ctrl_word;

  recfg_addr_decode u_dec (
    .addr_i  (mm_addr_i),
    .read_i  (mm_read_i),
    .write_i (mm_write_i),
    .acc_o   (acc)
  );

  recfg_ctrl_reg #(.DATA_W(DATA_W), .ST_W(ST_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (acc.ctrl_wr),
    .wr_start_i (mm_wdata_i[START_BIT]),
    .wr_dbl_i   (mm_wdata_i[DBL_BIT]),
    .status_i   (seq_status_i),
    .start_o    (seq_start_o),
    .dbl_o      (seq_double_o),
    .word_o     (ctrl_word)
  );

  recfg_word_port #(.DATA_W(DATA_W)) u_port (
    .push_i  (acc.data_wr),
    .wdata_i (mm_wdata_i),
    .ready_i (wd_ready_i),
    .data_o  (wd_data_o),
    .valid_o (wd_valid_o),
    .stall_o (mm_waitreq_o)
  );

  // The data word is write-only: reads of it return zero.
  assign mm_rdata_o = acc.ctrl_rd ? ctrl_word : '0;
endmodule

// File: rtl/recfg_mm_front_chk.sv
module recfg_mm_front_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mm_addr_i,
  input logic        mm_read_i,
  input logic        mm_write_i,
  input logic [31:0] mm_wdata_i,
  input logic [31:0] mm_rdata_o,
  input logic        mm_waitreq_o,
  input logic [2:0]  seq_status_i,
  input logic        seq_start_o,
  input logic        seq_double_o,
  input logic        wd_valid_o,
  input logic        wd_ready_i
);
  assert_stall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mm_write_i && !mm_addr_i && !wd_ready_i) |-> mm_waitreq_o);

  assert_no_stall_ctrl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mm_addr_i || !mm_write_i) |-> (!mm_waitreq_o && !wd_valid_o));

  assert_data_rd_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mm_read_i && !mm_write_i && !mm_addr_i) |-> (mm_rdata_o == 32'h0));

  assert_rsvd_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mm_read_i |-> (mm_rdata_o[31:5] == 27'h0));

  assert_status_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mm_read_i && mm_addr_i) |-> (mm_rdata_o[4:2] == seq_status_i));

  assert_start_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_start_o |=> !seq_start_o || $past(mm_write_i && mm_addr_i && mm_wdata_i[0]));

  assert_start_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mm_write_i && mm_addr_i && mm_wdata_i[0]) |=> seq_start_o);

  assert_double_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mm_write_i && mm_addr_i) |=> $stable(seq_double_o));
endmodule

bind recfg_mm_front recfg_mm_front_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mm_addr_i    (mm_addr_i),
  .mm_read_i    (mm_read_i),
  .mm_write_i   (mm_write_i),
  .mm_wdata_i   (mm_wdata_i),
  .mm_rdata_o   (mm_rdata_o),
  .mm_waitreq_o (mm_waitreq_o),
  .seq_status_i (seq_status_i),
  .seq_start_o  (seq_start_o),
  .seq_double_o (seq_double_o),
  .wd_valid_o   (wd_valid_o),
  .wd_ready_i   (wd_ready_i)
);

// File: tb/recfg_mm_front_tb.sv
`timescale 1ns/1ps
module recfg_mm_front_tb_top;
  logic        clk;
  logic        rst_n;
  logic        addr;
  logic        rd;
  logic        wr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        waitreq;
  logic [2:0]  status;
  logic        start;
  logic        dbl;
  logic [31:0] wd_data;
  logic        wd_valid;
  logic        wd_ready;

  int n_chk;
  int n_bad;
  bit done;

  int m_start;
  int m_dbl;
  logic [31:0] exp_q[$];

  recfg_mm_front dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mm_addr_i(addr), .mm_read_i(rd),
    .mm_write_i(wr), .mm_wdata_i(wdata), .mm_rdata_o(rdata),
    .mm_waitreq_o(waitreq), .seq_status_i(status), .seq_start_o(start),
    .seq_double_o(dbl), .wd_data_o(wd_data), .wd_valid_o(wd_valid),
    .wd_ready_i(wd_ready)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Reference model: state advances on each clock edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_start = 0;
      m_dbl   = 0;
    end else begin
      if (wr && !addr && wd_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R2 extra word", wd_data, 32'h0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk(wd_valid && wd_data == e, "R2 stream word", wd_data, e);
        end
      end
      if (wr && addr) begin
        m_start = int'(wdata[0]);
        m_dbl   = int'(wdata[1]);
      end else begin
        m_start = 0;
      end
    end
  end

  // Compare every cycle, well after the inputs change at the falling edge.
  always @(negedge clk) begin
    #3;
    if (rst_n && !done) begin
      logic ew;
      logic [31:0] er;
      ew = wr && !addr && !wd_ready;
      chk(waitreq == ew, "R3 waitrequest", {31'h0, waitreq}, {31'h0, ew});
      chk(wd_valid == (wr && !addr), "R2 valid", {31'h0, wd_valid}, {31'h0, wr && !addr});
      if (wr && !addr) chk(wd_data == wdata, "R2 data", wd_data, wdata);
      chk(start == m_start[0], "R5 start", {31'h0, start}, m_start);
      chk(dbl == m_dbl[0], "R6 double", {31'h0, dbl}, m_dbl);
      if (rd) begin
        er = addr ? {27'h0, status, m_dbl[0], m_start[0]} : 32'h0;
        chk(rdata == er, addr ? "R7 ctrl read" : "R4 data read", rdata, er);
      end
    end
  end

  task automatic bus_wr(input logic a, input logic [31:0] d, input int dly);
    @(negedge clk);
    addr = a; wr = 1'b1; wdata = d;
    if (!a) begin
      exp_q.push_back(d);
      wd_ready = (dly == 0);
      for (int i = 0; i < dly; i++) @(negedge clk);
      wd_ready = 1'b1;
    end
    @(posedge clk);
    while (waitreq) @(posedge clk);
    @(negedge clk);
    wr = 1'b0;
    wd_ready = 1'b0;
  endtask

  task automatic bus_rd(input logic a, output logic [31:0] d, output logic w);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #2;
    d = rdata;
    w = waitreq;
    @(posedge clk);
    @(negedge clk);
    rd = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic w;
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; addr = 1'b0; rd = 1'b0; wr = 1'b0; wdata = '0;
    status = 3'd0; wd_ready = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(!start && !dbl && !waitreq && !wd_valid, "R1 reset outputs",
        {28'h0, start, dbl, waitreq, wd_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!start && !dbl && !waitreq && !wd_valid, "R1 after release",
        {28'h0, start, dbl, waitreq, wd_valid}, 32'h0);

    // Single-pass start; bit 0 reads 1 during the pulse, 0 after it.
    status = 3'd4;
    bus_wr(1'b1, 32'h1, 0);
    #1 chk(start && !dbl, "R5 pulse high", {30'h0, dbl, start}, 32'h1);
    addr = 1'b1; rd = 1'b1; #1;
    chk(rdata == 32'h11, "R7 read during pulse", rdata, 32'h11);
    @(negedge clk); rd = 1'b0; #1;
    chk(!start, "R5 self clear", {31'h0, start}, 32'h0);
    repeat (2) @(negedge clk);
    bus_rd(1'b1, v, w);
    chk(v == 32'h10, "R5 bit0 cleared in readback", v, 32'h10);

    // Two-pass start.
    bus_wr(1'b1, 32'h3, 0);
    #1 chk(start && dbl, "R10 start with double", {30'h0, dbl, start}, 32'h3);
    @(negedge clk); #1;
    chk(!start && dbl, "R6 double held", {30'h0, dbl, start}, 32'h2);

    // Reserved bits are ignored; no stall on control writes even with ready low.
    bus_wr(1'b1, 32'hFFFF_FFE2, 0);
    bus_rd(1'b1, v, w);
    chk(v == 32'h12, "R8 reserved ignored", v, 32'h12);
    chk(!w, "R9 no wait on ctrl read", {31'h0, w}, 32'h0);

    // Status walk.
    for (int s = 0; s < 8; s++) begin
      status = 3'(s);
      bus_rd(1'b1, v, w);
      chk(v == {27'h0, 3'(s), 2'b10}, "R7 status field", v, {27'h0, 3'(s), 2'b10});
    end

    // Data writes with different sink delays.
    bus_wr(1'b0, 32'hA5A5_0001, 0);
    bus_wr(1'b0, 32'h5A5A_0002, 1);
    bus_wr(1'b0, 32'hDEAD_BEEF, 3);
    bus_wr(1'b0, 32'h0000_0004, 0);
    chk(exp_q.size() == 0, "R3 all words accepted", exp_q.size(), 32'h0);

    bus_rd(1'b0, v, w);
    chk(v == 32'h0, "R4 data word reads zero", v, 32'h0);
    chk(!w, "R9 no wait on data read", {31'h0, w}, 32'h0);

    // Control write with ready low: no stall, no stream word.
    @(negedge clk);
    addr = 1'b1; wr = 1'b1; wdata = 32'h0; wd_ready = 1'b0; #1;
    chk(!waitreq && !wd_valid, "R9 ctrl write no stall", {30'h0, waitreq, wd_valid}, 32'h0);
    @(negedge clk); wr = 1'b0; #1;
    chk(!dbl && !start, "R6 double cleared", {30'h0, dbl, start}, 32'h0);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule